// File: doc/BRIEF.md
# Three-Axis Element Index Remapper

This block turns the plain element count of a vector loop (0, 1, 2 ... VL-1) into a reordered element index. Software writes a 32-bit shape word that holds three axis sizes, an axis-ordering code and a three-bit offset. A start pulse then launches a loop of VL elements. The block walks an (x, y, z) counter whose nesting is set by the ordering code. For every element it emits `x + y*xd + z*xd*yd + offset`, where xd and yd are the decoded X and Y sizes. One ordering code gives the identity order. The others give transposed or reordered walks over the same 3D shape.

The index leaves on a valid/ready stream. `out_valid` stays high and `out_index` stays stable until `out_ready` is sampled high at a clock edge. Only that handshake advances the walk, so a consumer can apply back-pressure for any number of cycles. The configuration write port and the start/done pins are plain control signals with no handshake. The shape in force for a loop is captured when the loop starts. A new start abandons any loop in progress and begins again from element zero.

Top module: `elem_remap3d`

## Requirements
- R1: After reset `out_valid` and `done` are both low. The stored shape word is all zeros, which decodes to a 1x1x1 shape, identity order and offset 0.
- R2: The shape word holds each axis size as size minus one. X is in bits 6:0, Y in bits 14:8 and Z in bits 22:16, so each size ranges from 1 to 128.
- R3: The ordering code is in bits 26:24. Codes 0..5 select the axis order fast/middle/slow as X-Y-Z, X-Z-Y, Y-X-Z, Y-Z-X, Z-X-Y and Z-Y-X. Codes 6 and 7 behave as code 0. The fast axis steps on every handshake, the middle axis steps when the fast axis wraps, and the slow axis steps when both the fast and middle axes wrap.
- R4: Each emitted index equals x + y*xd + z*xd*yd + off. The offset off is a three-bit value: bit 0 is word bit 7, bit 1 is word bit 15 and bit 2 is word bit 23.
- R5: With sizes X=3, Y=2, Z=1, code 2 and offset 0, a loop of 6 elements emits 0, 3, 1, 4, 2, 5.
- R6: The walk advances only on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_index` holds its value.
- R7: In the cycle after a start with VL above zero, `out_valid` is high, `done` is low and the index is that of element (0,0,0), which is the offset.
- R8: After exactly VL handshakes, `out_valid` drops and `done` rises in the next cycle. `done` then stays high until the next start. A start with VL = 0 raises `done` in the next cycle without any valid cycle. `done` and `out_valid` are never high together.
- R9: When VL exceeds xd*yd*zd, all three counters wrap to zero after the last element of the shape and the walk repeats. When VL is smaller than that product, the loop ends after VL elements.
- R10: A loop uses the shape word captured at its start. A write in the same cycle as the start is used by that loop. A write during a loop does not change that loop's indices.
- R11: A start during a running loop resets the counters and the element count. The next cycle shows element zero of the new loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Shape word write strobe |
| cfg_wdata | input | 32 | Shape word to store |
| start | input | 1 | Begin a new loop of `start_vl` elements |
| start_vl | input | VL_W | Element count of the loop |
| out_ready | input | 1 | Consumer accepts the current index |
| out_valid | output | 1 | `out_index` holds a live element index |
| out_index | output | 22 | Remapped element index |
| done | output | 1 | Loop complete, held until the next start |

## Verification
The bench builds the block with VL_W = 8, so a loop can run up to 255 elements. Random shapes mix tiny axes (1 to 4), where 255 elements wrap the full shape many times, with axes up to 128, where the product is far beyond VL and every loop stops early. The full 7-bit size fields and all eight ordering codes, including the two aliases, are drawn at random. Random `out_ready` patterns exercise stalls of several cycles between handshakes. Directed loops cover the 3x2x1 transposed sequence, VL = 0, a start during a running loop, and configuration writes both alongside a start and in the middle of a loop.

// File: rtl/remap_pkg.sv
package remap_pkg;

  // Width of one stored axis size (size minus one).
  localparam int DIM_W   = 7;
  // Each axis occupies one byte lane of the shape word.
  localparam int LANE_W  = 8;
  localparam int N_AXES  = 3;
  localparam int OFFS_W  = 3;
  localparam int PERM_LSB = 24;
  localparam int PERM_W  = 3;
  localparam int WORD_W  = 32;
  // Largest index: 128^3 - 1 + 7 needs one bit above 3*DIM_W.
  localparam int IDX_W   = N_AXES * DIM_W + 1;

  typedef logic [DIM_W-1:0]  dim_t;
  typedef logic [1:0]        axis_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam axis_t AX_X = 2'd0;
  localparam axis_t AX_Y = 2'd1;
  localparam axis_t AX_Z = 2'd2;

  typedef struct packed {
    dim_t [N_AXES-1:0]    lim;   // per axis, stored size minus one
    logic [PERM_W-1:0]    perm;
    logic [OFFS_W-1:0]    offs;
  } shape_t;

  // Axis occupying each nesting position: [0] fast, [1] middle, [2] slow.
  typedef axis_t [N_AXES-1:0] order_t;

  function automatic shape_t unpack_shape(input logic [WORD_W-1:0] w);
    shape_t s;
    for (int a = 0; a < N_AXES; a++) begin
      s.lim[a]  = w[a*LANE_W +: DIM_W];
      s.offs[a] = w[a*LANE_W + LANE_W - 1];
    end
    s.perm = w[PERM_LSB +: PERM_W];
    return s;
  endfunction

  function automatic order_t perm_order(input logic [PERM_W-1:0] p);
    order_t o;
    case (p)
      3'd1:    begin o[0] = AX_X; o[1] = AX_Z; o[2] = AX_Y; end
      3'd2:    begin o[0] = AX_Y; o[1] = AX_X; o[2] = AX_Z; end
      3'd3:    begin o[0] = AX_Y; o[1] = AX_Z; o[2] = AX_X; end
      3'd4:    begin o[0] = AX_Z; o[1] = AX_X; o[2] = AX_Y; end
      3'd5:    begin o[0] = AX_Z; o[1] = AX_Y; o[2] = AX_X; end
      default: begin o[0] = AX_X; o[1] = AX_Y; o[2] = AX_Z; end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/remap_shape_reg.sv
// Holds the software-written shape word and captures the copy that a
// loop uses at its start; a write coinciding with start is forwarded.
module remap_shape_reg
  import remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              start,
  output shape_t            loop_shape,
  output order_t            loop_order
);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_eff;
  shape_t            snap_q;

  assign word_eff = cfg_we ? cfg_wdata : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (cfg_we) begin
      word_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (start) begin
      snap_q <= unpack_shape(word_eff);
    end
  end

  assign loop_shape = snap_q;
  assign loop_order = perm_order(snap_q.perm);

endmodule

// File: rtl/remap_walker.sv
// Three nested wrap-around counters; nesting order comes from loop_order.
module remap_walker
  import remap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                advance,
  input  dim_t [N_AXES-1:0]   lim,
  input  order_t              order,
  output dim_t [N_AXES-1:0]   coord
);

  logic [N_AXES-1:0] at_max;      // indexed by axis
  logic [N_AXES-1:0] pos_at_max;  // indexed by nesting position

  always_comb begin
    for (int p = 0; p < N_AXES; p++) begin
      pos_at_max[p] = at_max[order[p]];
    end
  end

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    dim_t cnt_q;
    logic step_en;

    assign at_max[a] = (cnt_q == lim[a]);

    always_comb begin
      step_en = 1'b0;
      if (advance) begin
        if (order[0] == axis_t'(a)) begin
          step_en = 1'b1;
        end else if (order[1] == axis_t'(a)) begin
          step_en = pos_at_max[0];
        end else begin
          step_en = pos_at_max[0] & pos_at_max[1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (clear) begin
        cnt_q <= '0;
      end else if (step_en) begin
        cnt_q <= at_max[a] ? '0 : cnt_q + 1'b1;
      end
    end

    assign coord[a] = cnt_q;
  end

endmodule

// File: rtl/remap_index.sv
// Linear index of the current coordinate plus the three-bit offset.
module remap_index
  import remap_pkg::*;
(
  input  dim_t [N_AXES-1:0]   lim,
  input  dim_t [N_AXES-1:0]   coord,
  input  logic [OFFS_W-1:0]   offs,
  output idx_t                index
);

  idx_t x_size;
  idx_t y_size;
  idx_t plane;
  idx_t row_part;
  idx_t plane_part;

  always_comb begin
    x_size     = idx_t'(lim[AX_X]) + idx_t'(1);
    y_size     = idx_t'(lim[AX_Y]) + idx_t'(1);
    plane      = x_size * y_size;
    row_part   = idx_t'(coord[AX_Y]) * x_size;
    plane_part = idx_t'(coord[AX_Z]) * plane;
    index      = idx_t'(coord[AX_X]) + row_part + plane_part + idx_t'(offs);
  end

endmodule

// File: rtl/remap_loop_ctrl.sv
// Element count, stream valid and completion flag of one loop.
module remap_loop_ctrl #(
  parameter int VL_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] start_vl,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            advance,
  output logic            done
);

  logic            active_q;
  logic            done_q;
  logic [VL_W-1:0] left_q;
  logic            accept;
  logic            last;

  assign accept = active_q & out_ready;
  assign last   = (left_q == VL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      left_q   <= '0;
    end else if (start) begin
      active_q <= (start_vl != '0);
      done_q   <= (start_vl == '0);
      left_q   <= start_vl;
    end else if (accept) begin
      left_q <= left_q - 1'b1;
      if (last) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign out_valid = active_q;
  assign done      = done_q;
  assign advance   = accept & ~start;

endmodule

// File: rtl/elem_remap3d.sv
module elem_remap3d
  import remap_pkg::*;
#(
  parameter int VL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              start,
  input  logic [VL_W-1:0]   start_vl,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [21:0]       out_index,
  output logic              done
);

  shape_t             shape;
  order_t             order;
  dim_t [N_AXES-1:0]  coord;
  logic               advance;
  idx_t               index;

  remap_shape_reg u_shape (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .start      (start),
    .loop_shape (shape),
    .loop_order (order)
  );

  remap_loop_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_vl  (start_vl),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .advance   (advance),
    .done      (done)
  );

  remap_walker u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .advance (advance),
    .lim     (shape.lim),
    .order   (order),
    .coord   (coord)
  );

  remap_index u_idx (
    .lim   (shape.lim),
    .coord (coord),
    .offs  (shape.offs),
    .index (index)
  );

  assign out_index = index;

endmodule

// File: rtl/elem_remap3d_chk.sv
module elem_remap3d_chk #(
  parameter int VL_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VL_W-1:0] start_vl,
  input logic            out_ready,
  input logic            out_valid,
  input logic [21:0]     out_index,
  input logic            done
);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_index)));

  // R8
  done_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && out_valid));

  // R7
  start_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_vl != '0) |=> (out_valid && !done));

  // R8
  empty_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_vl == '0) |=> (done && !out_valid));

  // R8
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && out_valid && !done) |=> (out_valid || $past(out_ready)));

endmodule

bind elem_remap3d elem_remap3d_chk #(.VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_vl  (start_vl),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_index (out_index),
  .done      (done)
);

// File: tb/elem_remap3d_tb.sv
`timescale 1ns/1ps
module elem_remap3d_tb;

  localparam int VL_W = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [31:0]     cfg_wdata = '0;
  logic            start = 1'b0;
  logic [VL_W-1:0] start_vl = '0;
  logic            out_ready = 1'b0;
  logic            out_valid;
  logic [21:0]     out_index;
  logic            done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  elem_remap3d #(.VL_W(VL_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .start     (start),
    .start_vl  (start_vl),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_index (out_index),
    .done      (done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] make_word(input int xs, input int ys, input int zs,
                                            input int perm, input int off);
    logic [31:0] w;
    w = '0;
    w[6:0]   = 7'(xs - 1);
    w[14:8]  = 7'(ys - 1);
    w[22:16] = 7'(zs - 1);
    w[26:24] = 3'(perm);
    w[7]     = off[0];
    w[15]    = off[1];
    w[23]    = off[2];
    return w;
  endfunction

  // Expected index of element k, by division rather than counting.
  function automatic longint model_index(input logic [31:0] w, input int k);
    longint d[3];
    longint c[3];
    int f, m, s;
    longint total, kk, off;
    d[0] = longint'(w[6:0]) + 1;
    d[1] = longint'(w[14:8]) + 1;
    d[2] = longint'(w[22:16]) + 1;
    case (w[26:24])
      3'd1: begin f = 0; m = 2; s = 1; end
      3'd2: begin f = 1; m = 0; s = 2; end
      3'd3: begin f = 1; m = 2; s = 0; end
      3'd4: begin f = 2; m = 0; s = 1; end
      3'd5: begin f = 2; m = 1; s = 0; end
      default: begin f = 0; m = 1; s = 2; end
    endcase
    total = d[0] * d[1] * d[2];
    kk = longint'(k) % total;
    c[f] = kk % d[f];
    c[m] = (kk / d[f]) % d[m];
    c[s] = kk / (d[f] * d[m]);
    off = longint'({w[23], w[15], w[7]});
    return c[0] + c[1] * d[0] + c[2] * d[0] * d[1] + off;
  endfunction

  // Write word, start a loop, drain it with random ready; optionally
  // overwrite the shape halfway (must not matter).
  task automatic run_loop(input logic [31:0] w, input int vl, input int ready_pct,
                          input bit mid_write, input string req);
    int  issued;
    bit  wrote;
    issued = 0;
    wrote  = 1'b0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    start = 1'b1; start_vl = VL_W'(vl);
    @(negedge clk);
    start = 1'b0;
    while (issued < vl) begin
      check(out_valid === 1'b1 && done === 1'b0, req, out_valid, 1);
      check(longint'(out_index) == model_index(w, issued), req,
            longint'(out_index), model_index(w, issued));
      if (!out_valid) break;
      out_ready = (($urandom % 100) < ready_pct);
      if (mid_write && !wrote && issued == vl / 2) begin
        cfg_we = 1'b1; cfg_wdata = $urandom; wrote = 1'b1;
      end
      if (out_ready) issued++;
      @(negedge clk);
      out_ready = 1'b0;
      cfg_we = 1'b0;
    end
    check(done === 1'b1 && out_valid === 1'b0, "R8", {done, out_valid}, 2'b10);
  endtask

  initial begin
    logic [31:0] w;
    int seq[6];
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1", out_valid, 0);
    check(done === 1'b0, "R1", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0, "R1", {out_valid, done}, 0);

    // R1: default shape 1x1x1, offset 0 -> index 0 repeated
    start = 1'b1; start_vl = 3;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(out_valid === 1'b1 && out_index == 0, "R1", out_index, 0);
      out_ready = 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(done === 1'b1, "R8", done, 1);

    // R5: 3x2x1 with Y fastest
    seq = '{0, 3, 1, 4, 2, 5};
    w = make_word(3, 2, 1, 2, 0);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b1; start_vl = 6;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check(out_valid === 1'b1 && out_index == seq[i], "R5", out_index, seq[i]);
      out_ready = 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(done === 1'b1 && out_valid === 1'b0, "R8", {done, out_valid}, 2'b10);
    // R8: done holds while idle
    repeat (3) @(negedge clk);
    check(done === 1'b1, "R8", done, 1);

    // R8: empty loop
    start = 1'b1; start_vl = 0;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1 && out_valid === 1'b0, "R8", {done, out_valid}, 2'b10);

    // R4 / R7: offset bits on first element, all offset bits set
    run_loop(make_word(4, 3, 2, 0, 7), 24, 100, 0, "R4");
    run_loop(make_word(5, 1, 1, 0, 5), 5, 60, 0, "R7");
    // R3: aliases 6 and 7 behave as identity
    run_loop(make_word(2, 3, 2, 6, 0), 12, 70, 0, "R3");
    run_loop(make_word(3, 2, 2, 7, 2), 12, 70, 0, "R3");
    // R9: wrap past the full shape, and early stop
    run_loop(make_word(2, 2, 1, 3, 0), 9, 100, 0, "R9");
    run_loop(make_word(128, 128, 128, 5, 1), 40, 80, 0, "R9");
    // R6: heavy back-pressure
    run_loop(make_word(3, 3, 3, 4, 3), 27, 20, 0, "R6");
    // R10: write mid-loop has no effect
    run_loop(make_word(4, 2, 3, 1, 0), 24, 70, 1, "R10");

    // R10: write in the same cycle as start is used
    cfg_we = 1'b1; cfg_wdata = make_word(2, 2, 2, 0, 0);
    @(negedge clk);
    w = make_word(3, 4, 1, 3, 6);
    cfg_wdata = w; start = 1'b1; start_vl = 4;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(longint'(out_index) == model_index(w, i), "R10", out_index, model_index(w, i));
      out_ready = 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b0;

    // R11: restart mid-loop
    w = make_word(3, 3, 1, 2, 1);
    cfg_we = 1'b1; cfg_wdata = w; start = 1'b1; start_vl = 9;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    out_ready = 1'b0; start = 1'b1; start_vl = 2;
    @(negedge clk);
    start = 1'b0;
    check(out_valid === 1'b1 && longint'(out_index) == model_index(w, 0), "R11",
          out_index, model_index(w, 0));
    out_ready = 1'b1;
    @(negedge clk);
    check(longint'(out_index) == model_index(w, 1), "R11", out_index, model_index(w, 1));
    @(negedge clk);
    out_ready = 1'b0;
    check(done === 1'b1 && out_valid === 1'b0, "R11", {done, out_valid}, 2'b10);

    // R2 / R3 / R4 / R9: random shapes
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < 60; t++) begin
      int xs, ys, zs, vl;
      if (t % 3 == 0) begin
        xs = 1 + $urandom % 128; ys = 1 + $urandom % 128; zs = 1 + $urandom % 128;
      end else begin
        xs = 1 + $urandom % 4; ys = 1 + $urandom % 4; zs = 1 + $urandom % 4;
      end
      vl = $urandom % 256;
      run_loop(make_word(xs, ys, zs, $urandom % 8, $urandom % 8), vl,
               30 + $urandom % 71, ($urandom % 4) == 0, "R2");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule